// File: doc/BRIEF.md
# Decode-Stage Hazard and Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline that resolves branches in decode. Each cycle it looks at the two source registers of the instruction being decoded and at the producers in the execute and memory stages. From these it decides whether the decoded instruction may advance. It drives the write enables of the program counter and of the fetch/decode pipeline register, a bubble request that clears the control fields entering execute, and a flush of the fetch/decode register.

Three producer cases force a stall. A load in execute whose destination is read by any decoded instruction is one. An ALU result in execute that a branch needs for its compare is another. The third is a load in the memory stage that a branch needs. A load that immediately precedes a branch meets the first and third cases on two successive cycles, so it costs two stall cycles. A load two places ahead costs one, as does an ALU result one place ahead. A taken branch discards the single wrong-path instruction fetched behind it, unless the branch is itself stalled that cycle. All outputs are combinational functions of the current inputs. The clock and reset ports serve only the embedded checks.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage instruction reads memory and its destination is non-zero and equals either decoded source register, the block stalls, whether or not the decoded instruction is a branch.
- R2: A stall is signalled consistently: `pc_we` and `ifid_we` are both 0 and `idex_bubble` is 1. With no stall, `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0. This includes the state while reset is held with all inputs at 0.
- R3: A decoded branch stalls when the execute-stage instruction writes a register (`ex_reg_write`=1) whose non-zero number equals either branch source.
- R4: A decoded branch stalls when the memory-stage instruction is a load (`mem_mem_read`=1 and `mem_reg_write`=1) whose non-zero destination equals either branch source. An ALU producer in the memory stage (`mem_mem_read`=0) causes no stall.
- R5: A decoded non-branch instruction is not stalled by an execute-stage ALU producer or by any memory-stage producer.
- R6: Register number 0 never causes a hazard, whatever the flags say.
- R7: A taken branch (`id_is_branch`=1, `branch_taken`=1) that is not stalled asserts `ifid_flush` while `pc_we` stays 1.
- R8: When a stall and a taken branch occur in the same cycle, the stall wins and `ifid_flush` stays 0.
- R9: `branch_taken` has no effect when `id_is_branch` is 0: `ifid_flush` stays 0.
- R10: A load immediately ahead of a branch that reads its result yields two consecutive stall cycles. The first comes while the load is in execute. The second comes while it is in the memory stage with a bubble behind it. The following cycle does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the embedded checks |
| id_rs | input | 5 | First source register of the decoded instruction |
| id_rt | input | 5 | Second source register of the decoded instruction |
| id_is_branch | input | 1 | Decoded instruction is a compare-and-branch |
| branch_taken | input | 1 | Decode-stage comparator outcome |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear control fields written into the decode/execute register |
| ifid_flush | output | 1 | Clear the fetch/decode register (wrong-path squash) |

## Verification
Directed patterns separate the producer kinds. One places a load in execute against a non-branch consumer, on either source. Another places an ALU result in execute against a branch and against a non-branch. A third places a load or an ALU result in the memory stage against a branch, which shows the memory-stage check reacts only to loads and only for branches. Register-zero cases and a three-cycle load-before-branch sequence check the two-cycle penalty and its end. Taken-branch cases with and without a simultaneous stall, and with the branch flag low, show the flush priority. A long run of random inputs, drawn from a narrow register range so that matches are frequent, is compared every cycle against a behavioural reference.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Reason for a decode stall; ordering gives reporting priority only.
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOAD_USE = 2'd1,
    CAUSE_BR_EX    = 2'd2,
    CAUSE_BR_MEM   = 2'd3
  } stall_cause_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC*AW-1:0] srcs,
  input  logic [AW-1:0]      dst,
  input  logic               qual,
  output logic               hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] hit_vec;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit_vec[i] = qual && (dst != ZERO_REG) && (dst == srcs[i*AW +: AW]);
    end
  endgenerate

  assign hit = |hit_vec;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
(
  input  logic         load_use_hit,
  input  logic         br_ex_hit,
  input  logic         br_mem_hit,
  input  logic         is_branch,
  input  logic         taken,
  output stall_cause_e cause,
  output logic         pc_we,
  output logic         ifid_we,
  output logic         bubble,
  output logic         flush
);
  logic stall;

  always_comb begin
    if (load_use_hit)    cause = CAUSE_LOAD_USE;
    else if (br_ex_hit)  cause = CAUSE_BR_EX;
    else if (br_mem_hit) cause = CAUSE_BR_MEM;
    else                 cause = CAUSE_NONE;
  end

  assign stall   = (cause != CAUSE_NONE);
  assign pc_we   = ~stall;
  assign ifid_we = ~stall;
  assign bubble  = stall;
  // A stalled branch is re-decoded next cycle, so its flush waits.
  assign flush   = is_branch && taken && !stall;
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_is_branch,
  input  logic          branch_taken,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_mem_read,
  input  logic          ex_reg_write,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_mem_read,
  input  logic          mem_reg_write,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  import hz_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC*AW-1:0] id_srcs;
  logic lu_hit, brex_hit, brmem_hit;
  logic brex_qual, brmem_qual;
  stall_cause_e cause;

  assign id_srcs    = {id_rt, id_rs};
  assign brex_qual  = id_is_branch && ex_reg_write;
  assign brmem_qual = id_is_branch && mem_mem_read && mem_reg_write;

  hz_src_match #(.AW(AW), .NSRC(NSRC)) u_load_use (
    .srcs(id_srcs), .dst(ex_dst), .qual(ex_mem_read), .hit(lu_hit)
  );

  hz_src_match #(.AW(AW), .NSRC(NSRC)) u_br_ex (
    .srcs(id_srcs), .dst(ex_dst), .qual(brex_qual), .hit(brex_hit)
  );

  hz_src_match #(.AW(AW), .NSRC(NSRC)) u_br_mem (
    .srcs(id_srcs), .dst(mem_dst), .qual(brmem_qual), .hit(brmem_hit)
  );

  hz_stall_ctrl u_ctrl (
    .load_use_hit(lu_hit),
    .br_ex_hit   (brex_hit),
    .br_mem_hit  (brmem_hit),
    .is_branch   (id_is_branch),
    .taken       (branch_taken),
    .cause       (cause),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .bubble      (idex_bubble),
    .flush       (ifid_flush)
  );

  // R1: a load feeding any decoded source must hold the front end
  a_r1_load_use_stall: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && ex_dst != '0 && (ex_dst == id_rs || ex_dst == id_rt))
      |-> (idex_bubble && !pc_we));

  // R2: the three stall controls move together
  a_r2_stall_coherent: assert property (@(posedge clk) disable iff (rst)
    (pc_we == ifid_we) && (idex_bubble == !pc_we));

  // R6: with both producers naming register zero nothing stalls
  a_r6_zero_reg_free: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == '0 && mem_dst == '0) |-> !idex_bubble);

  // R8: a flush never coincides with a held front end
  a_r8_flush_yields: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |-> (pc_we && ifid_we));

  // R9: without a decoded branch the taken flag does nothing
  a_r9_taken_ignored: assert property (@(posedge clk) disable iff (rst)
    !id_is_branch |-> !ifid_flush);

  // R5: non-branch consumers are never held by a non-load producer
  a_r5_nonbranch_free: assert property (@(posedge clk) disable iff (rst)
    (!id_is_branch && !ex_mem_read) |-> pc_we);
endmodule

// File: tb/tb_hazard_stall_unit.sv
module tb_hazard_stall_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
  logic id_is_branch = 1'b0, branch_taken = 1'b0;
  logic ex_mem_read = 1'b0, ex_reg_write = 1'b0;
  logic mem_mem_read = 1'b0, mem_reg_write = 1'b0;
  logic pc_we, ifid_we, idex_bubble, ifid_flush;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hazard_stall_unit #(.AW(AW)) dut (
    .clk(clk), .rst(rst),
    .id_rs(id_rs), .id_rt(id_rt),
    .id_is_branch(id_is_branch), .branch_taken(branch_taken),
    .ex_dst(ex_dst), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .mem_dst(mem_dst), .mem_mem_read(mem_mem_read), .mem_reg_write(mem_reg_write),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  function automatic bit reads(input logic [AW-1:0] r);
    return (r != 0) && (r == id_rs || r == id_rt);
  endfunction

  function automatic bit model_stall();
    bit s;
    s = 0;
    if (ex_mem_read && reads(ex_dst)) s = 1;
    if (id_is_branch && ex_reg_write && reads(ex_dst)) s = 1;
    if (id_is_branch && mem_mem_read && mem_reg_write && reads(mem_dst)) s = 1;
    return s;
  endfunction

  task automatic check(input string tag, input bit exp_stall);
    bit exp_flush;
    logic [3:0] act, exp;
    exp_flush = id_is_branch && branch_taken && !exp_stall;
    act = {pc_we, ifid_we, idex_bubble, ifid_flush};
    exp = {!exp_stall, !exp_stall, exp_stall, exp_flush};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act{pc_we,ifid_we,bubble,flush}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] rs, rt, input bit br, tk,
                       input logic [AW-1:0] ed, input bit emr, erw,
                       input logic [AW-1:0] md, input bit mmr, mrw);
    @(posedge clk); #1;
    id_rs = rs; id_rt = rt; id_is_branch = br; branch_taken = tk;
    ex_dst = ed; ex_mem_read = emr; ex_reg_write = erw;
    mem_dst = md; mem_mem_read = mmr; mem_reg_write = mrw;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset", 1'b0);
    @(posedge clk); #1; rst = 1'b0;

    drive(5'd3, 5'd4, 0, 0, 5'd3, 1, 1, 5'd0, 0, 0); check("R1 load rs", 1'b1);
    drive(5'd3, 5'd4, 0, 0, 5'd4, 1, 1, 5'd0, 0, 0); check("R1 load rt", 1'b1);
    drive(5'd3, 5'd4, 1, 0, 5'd4, 1, 1, 5'd0, 0, 0); check("R1 load branch", 1'b1);
    drive(5'd3, 5'd4, 0, 0, 5'd7, 1, 1, 5'd0, 0, 0); check("R2 no match", 1'b0);
    drive(5'd0, 5'd0, 1, 0, 5'd0, 1, 1, 5'd0, 1, 1); check("R6 zero reg", 1'b0);
    drive(5'd0, 5'd2, 1, 1, 5'd0, 0, 1, 5'd0, 1, 1); check("R6 zero branch", 1'b0);
    drive(5'd6, 5'd8, 1, 0, 5'd8, 0, 1, 5'd0, 0, 0); check("R3 alu ex br", 1'b1);
    drive(5'd6, 5'd8, 0, 0, 5'd8, 0, 1, 5'd0, 0, 0); check("R5 alu ex nonbr", 1'b0);
    drive(5'd6, 5'd8, 1, 0, 5'd8, 0, 0, 5'd0, 0, 0); check("R3 no write", 1'b0);
    drive(5'd9, 5'd1, 1, 0, 5'd0, 0, 0, 5'd9, 1, 1); check("R4 load mem br", 1'b1);
    drive(5'd9, 5'd1, 1, 0, 5'd0, 0, 0, 5'd9, 0, 1); check("R4 alu mem br", 1'b0);
    drive(5'd9, 5'd1, 0, 0, 5'd0, 0, 0, 5'd9, 1, 1); check("R5 load mem nonbr", 1'b0);
    // R10: load directly before a taken branch: two stalls then flush
    drive(5'd5, 5'd0, 1, 1, 5'd5, 1, 1, 5'd0, 0, 0); check("R10 cycle1", 1'b1);
    drive(5'd5, 5'd0, 1, 1, 5'd0, 0, 0, 5'd5, 1, 1); check("R10 cycle2", 1'b1);
    drive(5'd5, 5'd0, 1, 1, 5'd0, 0, 0, 5'd0, 0, 0); check("R10 cycle3 R7", 1'b0);
    drive(5'd2, 5'd3, 1, 1, 5'd9, 0, 1, 5'd0, 0, 0); check("R7 taken flush", 1'b0);
    drive(5'd2, 5'd3, 1, 1, 5'd3, 0, 1, 5'd0, 0, 0); check("R8 stall beats flush", 1'b1);
    drive(5'd2, 5'd3, 0, 1, 5'd9, 0, 1, 5'd0, 0, 0); check("R9 taken nonbr", 1'b0);

    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom));
      check("R2 random", model_stall());
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule